// File: doc/BRIEF.md
# Block-Transfer Micro-Op Sequencer

This block turns one multi-register load or store instruction into an ordered stream of simple micro-ops, one per cycle. The instruction arrives over a valid/ready handshake. It carries a base register index, a 16-bit register mask and five control bits: direction (up or down), pre-index, load or store, base writeback, and user-bank access. A sixth bit marks the load-and-return variant. The micro-ops leave over a second valid/ready handshake. Each one carries an opcode, a destination or data register index, a source register index, an 8-bit immediate, a direction flag and an end-of-sequence flag.

Every sequence starts by copying the base into a scratch register. The copy is an add of zero. Next comes one transfer per set mask bit, lowest register first. Each transfer addresses memory as the scratch register plus or minus a running byte offset. A writeback micro-op that moves the base past the whole block can follow at the end. The total micro-op count is 1 + popcount(mask) + writeback. The block works this count out when it accepts the instruction.

Register index space is 6 bits wide. Values 0..15 are the current-mode registers, 16..31 are the user-bank aliases of registers 0..15 (index 16+r), and 32 is the scratch register.

Top module: `lsm_uop_seq`

## Requirements
- R1: `in_ready_o` is high only while no sequence is in flight. An instruction accepted at a clock edge makes its first micro-op valid right after that edge.
- R2: The first micro-op of every sequence has opcode 0 (add-immediate), destination 32 (scratch), source equal to the base index, immediate 0 and up flag 1.
- R3: Each set mask bit produces one transfer micro-op, in ascending register order. The opcode is 2 (load) or 3 (store), the data index is the register number and the source is 32.
- R4: The first transfer's immediate is 0 in up mode and 4·n−4 in down mode, where n is the number of set mask bits. When the pre-index bit is set, 4 is added to that value.
- R5: Each following transfer's immediate is 4 higher than the previous one in up mode and 4 lower in down mode. Every transfer carries the instruction's direction in its up flag.
- R6: With the user-bank bit set, every transfer's data index is 16 plus the register number.
- R7: With writeback set, a final micro-op is appended. Its opcode is 0 in up mode and 1 (subtract-immediate) in down mode, destination and source are both the base index, and the immediate is 4·n.
- R8: The last flag is set on exactly the final micro-op of each sequence.
- R9: For a load with the return bit set, the final transfer uses opcode 4 (load-and-return) instead of 2. For stores the return bit has no effect.
- R10: While `out_valid_o` is high and `out_ready_i` is low, all micro-op outputs hold their values.
- R11: With an empty mask, the sequence is the scratch copy alone. With writeback set it is the scratch copy followed by an add or subtract of 0 on the base.
- R12: After the micro-op flagged last is taken, `out_valid_o` drops and `in_ready_o` rises on the next cycle. No instruction is accepted earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Instruction offered |
| in_ready_o | output | 1 | Sequencer idle, instruction taken at this edge |
| base_i | input | 4 | Base register index |
| mask_i | input | 16 | Register mask |
| up_i | input | 1 | 1: addresses ascend, 0: descend |
| pre_i | input | 1 | Pre-index: start offset +4 |
| load_i | input | 1 | 1: load, 0: store |
| wb_i | input | 1 | Append base update |
| user_i | input | 1 | Map transfer registers to user bank |
| ret_i | input | 1 | Final load is load-and-return |
| out_valid_o | output | 1 | Micro-op valid |
| out_ready_i | input | 1 | Consumer takes micro-op |
| op_o | output | 3 | Opcode: 0 addi, 1 subi, 2 load, 3 store, 4 load-return |
| ra_o | output | 6 | Destination / data register index |
| rb_o | output | 6 | Source register index |
| imm_o | output | 8 | Immediate byte offset |
| up_o | output | 1 | Direction flag |
| last_o | output | 1 | Final micro-op of the sequence |

## Verification
The first micro-op is due in the cycle right after the accepting edge. Each later micro-op is due in the cycle after the edge where the previous one was taken. The idle state returns one cycle after the last one is taken. All inputs change on the falling edge and all outputs are read on the falling edge, so each read sees the settled state left by the most recent rising edge. Under randomly withheld `out_ready_i`, a micro-op is compared with the expected stream only in a cycle where the bench also asserts ready. In the stalled cycles it is compared with its own earlier value, which checks the hold rule.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [2:0] {
    UOP_ADDI     = 3'd0,
    UOP_SUBI     = 3'd1,
    UOP_LOAD     = 3'd2,
    UOP_STORE    = 3'd3,
    UOP_LOAD_RET = 3'd4
  } uop_op_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_COPY = 2'd1,
    PH_XFER = 2'd2,
    PH_WB   = 2'd3
  } seq_ph_e;
endpackage

// File: rtl/lsm_popcnt.sv
module lsm_popcnt #(
  parameter int W  = 16,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) cnt_o = cnt_o + CW'(vec_i[i]);
  end
endmodule

// File: rtl/lsm_low_pick.sv
module lsm_low_pick #(
  parameter int W  = 16,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic [W-1:0]  rest_o,
  output logic          single_o
);
  logic [W-1:0] below;  // below[i]: some bit under i is set

  assign below[0] = 1'b0;
  for (genvar g = 1; g < W; g++) begin : g_chain
    assign below[g] = below[g-1] | vec_i[g-1];
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++)
      if (vec_i[i] && !below[i]) idx_o = IW'(i);
  end

  assign rest_o   = vec_i & (vec_i - W'(1));
  assign single_o = (vec_i != '0) && (rest_o == '0);
endmodule

// File: rtl/lsm_reg_map.sv
module lsm_reg_map #(
  parameter int REG_W = 4,
  parameter int IDX_W = REG_W + 2
) (
  input  logic [REG_W-1:0] reg_i,
  input  logic             user_i,
  output logic [IDX_W-1:0] idx_o
);
  assign idx_o = {1'b0, user_i, reg_i};
endmodule

// File: rtl/lsm_uop_seq.sv
module lsm_uop_seq
  import lsm_pkg::*;
#(
  parameter int NREG       = 16,
  parameter int IMM_W      = 8,
  parameter int WORD_BYTES = 4,
  parameter int REG_W      = $clog2(NREG),
  parameter int IDX_W      = REG_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [REG_W-1:0] base_i,
  input  logic [NREG-1:0]  mask_i,
  input  logic             up_i,
  input  logic             pre_i,
  input  logic             load_i,
  input  logic             wb_i,
  input  logic             user_i,
  input  logic             ret_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [2:0]       op_o,
  output logic [IDX_W-1:0] ra_o,
  output logic [IDX_W-1:0] rb_o,
  output logic [IMM_W-1:0] imm_o,
  output logic             up_o,
  output logic             last_o
);
  localparam int PC_W  = $clog2(NREG + 1);
  localparam int CNT_W = $clog2(NREG + 3);
  localparam logic [IDX_W-1:0] SCRATCH_IDX = IDX_W'(1) << (IDX_W - 1);
  localparam logic [IMM_W-1:0] STEP        = IMM_W'(WORD_BYTES);

  seq_ph_e          ph_q;
  logic [NREG-1:0]  mask_q;
  logic [IMM_W-1:0] off_q, span_q;
  logic [CNT_W-1:0] left_q;
  logic [REG_W-1:0] base_q;
  logic             up_q, load_q, wb_q, user_q, ret_q;

  logic [PC_W-1:0]  in_cnt;
  logic [IMM_W-1:0] in_span, in_start;
  logic [REG_W-1:0] cur_reg;
  logic [NREG-1:0]  mask_rest;
  logic             mask_single;
  logic [IDX_W-1:0] cur_idx;
  logic             accept, fire;

  lsm_popcnt #(.W(NREG), .CW(PC_W)) u_popcnt (
    .vec_i (mask_i),
    .cnt_o (in_cnt)
  );

  lsm_low_pick #(.W(NREG), .IW(REG_W)) u_pick (
    .vec_i    (mask_q),
    .idx_o    (cur_reg),
    .rest_o   (mask_rest),
    .single_o (mask_single)
  );

  lsm_reg_map #(.REG_W(REG_W), .IDX_W(IDX_W)) u_map (
    .reg_i  (cur_reg),
    .user_i (user_q),
    .idx_o  (cur_idx)
  );

  assign in_span = IMM_W'(in_cnt) * STEP;

  always_comb begin
    in_start = up_i ? '0 : (in_span - STEP);
    if (pre_i) in_start = in_start + STEP;
  end

  assign in_ready_o  = (ph_q == PH_IDLE);
  assign out_valid_o = (ph_q != PH_IDLE);
  assign accept      = in_valid_i & in_ready_o;
  assign fire        = out_valid_o & out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      mask_q <= '0;
      off_q  <= '0;
      span_q <= '0;
      left_q <= '0;
      base_q <= '0;
      up_q   <= 1'b0;
      load_q <= 1'b0;
      wb_q   <= 1'b0;
      user_q <= 1'b0;
      ret_q  <= 1'b0;
    end else if (accept) begin
      ph_q   <= PH_COPY;
      mask_q <= mask_i;
      off_q  <= in_start;
      span_q <= in_span;
      left_q <= CNT_W'(in_cnt) + CNT_W'(1) + CNT_W'(wb_i);
      base_q <= base_i;
      up_q   <= up_i;
      load_q <= load_i;
      wb_q   <= wb_i;
      user_q <= user_i;
      ret_q  <= ret_i;
    end else if (fire) begin
      left_q <= left_q - CNT_W'(1);
      unique case (ph_q)
        PH_COPY: begin
          if (mask_q != '0) ph_q <= PH_XFER;
          else if (wb_q)    ph_q <= PH_WB;
          else              ph_q <= PH_IDLE;
        end
        PH_XFER: begin
          mask_q <= mask_rest;
          off_q  <= up_q ? (off_q + STEP) : (off_q - STEP);
          if (mask_single) ph_q <= wb_q ? PH_WB : PH_IDLE;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    op_o  = UOP_ADDI;
    ra_o  = SCRATCH_IDX;
    rb_o  = IDX_W'(base_q);
    imm_o = '0;
    up_o  = 1'b1;
    unique case (ph_q)
      PH_XFER: begin
        if (!load_q)                   op_o = UOP_STORE;
        else if (ret_q && mask_single) op_o = UOP_LOAD_RET;
        else                           op_o = UOP_LOAD;
        ra_o  = cur_idx;
        rb_o  = SCRATCH_IDX;
        imm_o = off_q;
        up_o  = up_q;
      end
      PH_WB: begin
        op_o  = up_q ? UOP_ADDI : UOP_SUBI;
        ra_o  = IDX_W'(base_q);
        imm_o = span_q;
        up_o  = up_q;
      end
      default: ;
    endcase
  end

  assign last_o = out_valid_o && (left_q == CNT_W'(1));
endmodule

// File: rtl/lsm_uop_seq_chk.sv
module lsm_uop_seq_chk #(
  parameter int IDX_W = 6,
  parameter int IMM_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [2:0]       op_o,
  input logic [IDX_W-1:0] ra_o,
  input logic [IDX_W-1:0] rb_o,
  input logic [IMM_W-1:0] imm_o,
  input logic             up_o,
  input logic             last_o
);
  localparam logic [IDX_W-1:0] SCR = IDX_W'(1) << (IDX_W - 1);

  logic fire, xfer;
  assign fire = out_valid_o & out_ready_i;
  assign xfer = (op_o == 3'd2) || (op_o == 3'd3) || (op_o == 3'd4);

  p_idle_only_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> !out_valid_o);

  p_first_copy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=>
      (out_valid_o && op_o == 3'd0 && ra_o == SCR && imm_o == '0 && up_o));

  p_xfer_scratch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && xfer) |-> (rb_o == SCR));

  p_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && xfer && !last_o) |=>
      (!xfer || imm_o == (up_o ? $past(imm_o) + IMM_W'(4) : $past(imm_o) - IMM_W'(4))));

  p_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && last_o) |=> (!out_valid_o && in_ready_o));

  p_more_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !last_o) |=> out_valid_o);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(op_o) && $stable(ra_o) && $stable(rb_o) &&
       $stable(imm_o) && $stable(up_o) && $stable(last_o)));

  p_op_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (op_o <= 3'd4));
endmodule

bind lsm_uop_seq lsm_uop_seq_chk #(.IDX_W(IDX_W), .IMM_W(IMM_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .op_o        (op_o),
  .ra_o        (ra_o),
  .rb_o        (rb_o),
  .imm_o       (imm_o),
  .up_o        (up_o),
  .last_o      (last_o)
);

// File: tb/tb_lsm_uop_seq.sv
`timescale 1ns/1ps
module tb_lsm_uop_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [3:0]  base_i = '0;
  logic [15:0] mask_i = '0;
  logic        up_i = 1'b0, pre_i = 1'b0, load_i = 1'b0, wb_i = 1'b0, user_i = 1'b0, ret_i = 1'b0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b0;
  logic [2:0]  op_o;
  logic [5:0]  ra_o, rb_o;
  logic [7:0]  imm_o;
  logic        up_o, last_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int e_op[18], e_ra[18], e_rb[18], e_imm[18], e_up[18];
  string e_tag[18];
  int e_n;

  always #2.5 clk_i = ~clk_i;

  lsm_uop_seq dut (
    .clk_i, .rst_ni, .in_valid_i, .in_ready_o, .base_i, .mask_i,
    .up_i, .pre_i, .load_i, .wb_i, .user_i, .ret_i,
    .out_valid_o, .out_ready_i, .op_o, .ra_o, .rb_o, .imm_o, .up_o, .last_o
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic build(input int b, input logic [15:0] m, input bit up, input bit pre,
                       input bit ld, input bit wb, input bit usr, input bit ret);
    int n, off, seen;
    n = $countones(m);
    e_op[0] = 0; e_ra[0] = 32; e_rb[0] = b; e_imm[0] = 0; e_up[0] = 1;
    e_tag[0] = (n == 0) ? "R11" : "R2";
    e_n = 1;
    off = up ? 0 : 4*n - 4;
    if (pre) off += 4;
    seen = 0;
    for (int r = 0; r < 16; r++) begin
      if (m[r]) begin
        seen++;
        e_op[e_n]  = !ld ? 3 : ((ret && seen == n) ? 4 : 2);
        e_ra[e_n]  = usr ? 16 + r : r;
        e_rb[e_n]  = 32;
        e_imm[e_n] = off & 255;
        e_up[e_n]  = up;
        if (ld && ret && seen == n) e_tag[e_n] = "R9";
        else if (usr)               e_tag[e_n] = "R6";
        else if (seen == 1)         e_tag[e_n] = "R4";
        else                        e_tag[e_n] = "R5";
        off = up ? off + 4 : off - 4;
        e_n++;
      end
    end
    if (wb) begin
      e_op[e_n] = up ? 0 : 1; e_ra[e_n] = b; e_rb[e_n] = b;
      e_imm[e_n] = 4*n; e_up[e_n] = up;
      e_tag[e_n] = (n == 0) ? "R11" : "R7";
      e_n++;
    end
  endtask

  task automatic run(input int b, input logic [15:0] m, input bit up, input bit pre,
                     input bit ld, input bit wb, input bit usr, input bit ret,
                     input int rdy_pct);
    int k;
    logic [2:0] h_op; logic [5:0] h_ra, h_rb; logic [7:0] h_imm; logic h_up, h_last;
    bit held;
    build(b, m, up, pre, ld, wb, usr, ret);
    @(negedge clk_i);
    chk(in_ready_o === 1'b1, "R12 idle before accept", int'(in_ready_o), 1);
    in_valid_i = 1'b1; base_i = b[3:0]; mask_i = m; up_i = up; pre_i = pre;
    load_i = ld; wb_i = wb; user_i = usr; ret_i = ret;
    k = 0; held = 1'b0;
    h_op = '0; h_ra = '0; h_rb = '0; h_imm = '0; h_up = 1'b0; h_last = 1'b0;
    while (k < e_n) begin
      @(negedge clk_i);
      in_valid_i = 1'b0;
      mask_i = $urandom;
      base_i = $urandom;
      if (out_valid_o !== 1'b1) begin
        chk(1'b0, "R1 valid while sequence pending", int'(out_valid_o), 1);
        out_ready_i = 1'b0;
        break;
      end
      if (k == 0) chk(in_ready_o === 1'b0, "R1 busy blocks accept", int'(in_ready_o), 0);
      if (held)
        chk(op_o == h_op && ra_o == h_ra && rb_o == h_rb && imm_o == h_imm &&
            up_o == h_up && last_o == h_last, "R10 hold", int'(imm_o), int'(h_imm));
      if (($urandom % 100) < rdy_pct) begin
        out_ready_i = 1'b1; held = 1'b0;
        chk(op_o == e_op[k], {e_tag[k], " R3 op"}, int'(op_o), e_op[k]);
        chk(ra_o == e_ra[k] && rb_o == e_rb[k], {e_tag[k], " regs"},
            int'(ra_o) * 64 + int'(rb_o), e_ra[k] * 64 + e_rb[k]);
        chk(imm_o == e_imm[k], {e_tag[k], " imm"}, int'(imm_o), e_imm[k]);
        chk(up_o == e_up[k], {e_tag[k], " R5 up"}, int'(up_o), e_up[k]);
        chk(last_o == (k == e_n - 1), "R8 last", int'(last_o), int'(k == e_n - 1));
        k++;
      end else begin
        out_ready_i = 1'b0; held = 1'b1;
        h_op = op_o; h_ra = ra_o; h_rb = rb_o; h_imm = imm_o; h_up = up_o; h_last = last_o;
      end
    end
    @(negedge clk_i);
    out_ready_i = 1'b0;
    chk(out_valid_o === 1'b0 && in_ready_o === 1'b1, "R12 idle after last",
        int'(out_valid_o), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #12;
    chk(out_valid_o === 1'b0 && in_ready_o === 1'b1, "R1 reset state", int'(out_valid_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // directed corners
    run(3, 16'h0000, 1, 0, 1, 0, 0, 0, 100);   // R11 copy only
    run(5, 16'h0000, 0, 1, 0, 1, 0, 0, 100);   // R11 zero-size subtract
    run(13, 16'hFFFF, 0, 1, 0, 1, 0, 0, 60);   // R4 down pre full: start 64
    run(13, 16'hFFFF, 1, 0, 1, 1, 0, 1, 50);   // R7 R9 full up load
    run(2, 16'h8000, 0, 0, 1, 0, 0, 1, 100);   // single transfer, R9
    run(7, 16'h0501, 1, 1, 0, 0, 1, 1, 40);    // R6 user bank, R9 store no effect
    run(0, 16'h00F0, 1, 0, 1, 1, 1, 0, 30);    // R10 heavy stall
    for (int i = 0; i < 250; i++) begin
      logic [15:0] m;
      m = $urandom;
      if (($urandom % 4) == 0) m = m & $urandom & $urandom;
      run($urandom % 16, m, $urandom % 2, $urandom % 2, $urandom % 2,
          $urandom % 2, $urandom % 2, $urandom % 2, 50 + ($urandom % 51));
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule